// File: doc/BRIEF.md
# Serial Back-Channel Message Receiver

This block receives input-device reports from a raster terminal. The terminal sends them serially, one bit per video scan line, on a single wire. A per-line strobe samples the wire once per scan line. While nothing is arriving the line rests at zero. A one marks the start of a 32-bit message, and the receiver gathers the remaining 31 bits most-significant-first. The message is accepted only if its last eight bits hold the fixed trailer pattern.

An accepted message carries a 4-bit type that selects its destination:
- Six keyboard state words are each overwritten by the 16-bit body of their own type.
- A button/keyset word is overwritten the same way by its type.
- A mouse-motion type produces a one-cycle valid pulse with signed X and Y deltas.
- Every other type is dropped.

A held boot key forces the line to a constant one. A separate run-length detector raises a boot flag after a minimum run of ones, which filters out short noise pushes. It drops the flag only after a run of zeros long enough to pass over the garbage bits the terminal may send when the key is released.

Top module: `term_backlink_rx`

## Requirements
- R1: While hunting, a sampled 0 is ignored. A sampled 1 (only when `line_stb` is high) is the first bit of a 32-bit message.
- R2: Message bits are taken most-significant-first, giving a word with these fields:
  - bit 31: start bit, always 1
  - bits 30:28: unused, any value
  - bits 27:24: type
  - bits 23:8: body
  - bits 7:0: trailer
- R3: A message whose trailer is not 8'h80 changes no output and produces no mouse pulse.
- R4: Types 1, 2, 3, 4, 8 and 9 write the body into keyboard words 0, 1, 2, 3, 4 and 5 respectively.
  - Keyboard word k is `key_flat[16k+15:16k]`.
  - The new value is visible two clock cycles after the strobe edge that samples the last message bit.
- R5: Type 5 writes the body into `btn_word`, with the same timing as R4.
- R6: Type 6 raises `mouse_vld` for exactly one cycle and changes no stored word.
  - `mouse_dx` = body[15:8] − 128, as signed 8-bit.
  - `mouse_dy` = body[7:0] − 128, as signed 8-bit.
- R7: Types 0, 7, 10, 11, 12, 13, 14 and 15 change no output.
- R8: `boot_flag` sets on the BOOT_MIN_LINES-th consecutive sampled 1 (default 40). A shorter run of ones leaves it clear.
- R9: Once set, `boot_flag` clears on the CLEAR_LINES-th consecutive sampled 0 (default 12). Shorter zero runs leave it set.
- R10: After the 32nd bit the receiver hunts again. A 1 on the very next strobe starts a new message.
- R11: Reset clears all keyboard words, the button word, `mouse_vld` and `boot_flag`, and abandons any partly received message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle strobe, once per scan line |
| ser_bit | input | 1 | Serial back-channel bit |
| key_flat | output | KEY_WORDS*16 | Keyboard state words, word k at bits 16k+15:16k |
| btn_word | output | 16 | Mouse-button/keyset word |
| mouse_vld | output | 1 | One-cycle pulse for a mouse-motion message |
| mouse_dx | output | 8 | Signed X delta |
| mouse_dy | output | 8 | Signed Y delta |
| boot_flag | output | 1 | Boot key held |

## Verification
The hardest situation to reach from the ports is a boot sequence and a message framer working on the same stream. A long run of ones also forms all-ones frames, and the garbage after release leaves a partial frame that must end with a trailer mismatch rather than a spurious update. The stimulus holds the line at one for exactly one line short of the boot threshold, then for the threshold itself. It then releases with an 8-bit garbage pattern whose zero runs stay below the clear count. The flag and every stored word are checked at each boundary. A separate sequence asserts reset halfway through a message and then checks that the next message is framed from its own start bit.

// File: rtl/term_backlink_pkg.sv
package term_backlink_pkg;

    localparam int unsigned FRAME_BITS = 32;
    localparam int unsigned BODY_W     = 16;
    localparam int unsigned DELTA_W    = 8;
    localparam logic [7:0]  TRAILER_OK = 8'h80;
    localparam logic [3:0]  TYPE_BTN   = 4'd5;
    localparam logic [3:0]  TYPE_MOUSE = 4'd6;

    typedef enum logic {
        ST_HUNT    = 1'b0,
        ST_COLLECT = 1'b1
    } frame_state_e;

    // keyboard slot k is written by type k+1 for the first four slots, k+4 after
    function automatic logic [3:0] key_type_code(int unsigned slot);
        return (slot < 4) ? 4'(slot + 1) : 4'(slot + 4);
    endfunction

endpackage

// File: rtl/backlink_framer.sv
module backlink_framer
    import term_backlink_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_stb,
    input  logic                  ser_bit,
    output logic                  frame_vld,
    output logic [FRAME_BITS-1:0] frame_word
);

    localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        frame_state_e          state;
        logic [FRAME_BITS-1:0] shreg;
        logic [CNT_W-1:0]      cnt;
        logic                  vld;
    } framer_t;

    framer_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (line_stb) begin
            unique case (st_q.state)
                ST_HUNT: begin
                    if (ser_bit) begin
                        st_d.shreg = {{(FRAME_BITS-1){1'b0}}, 1'b1};
                        st_d.cnt   = CNT_W'(1);
                        st_d.state = ST_COLLECT;
                    end
                end
                ST_COLLECT: begin
                    st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], ser_bit};
                    if (st_q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                        st_d.vld   = 1'b1;
                        st_d.cnt   = '0;
                        st_d.state = ST_HUNT;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                default: st_d.state = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_HUNT, shreg: '0, cnt: '0, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_vld  = st_q.vld;
    assign frame_word = st_q.shreg;

endmodule

// File: rtl/backlink_boot_det.sv
module backlink_boot_det #(
    parameter int unsigned BOOT_MIN_LINES = 40,
    parameter int unsigned CLEAR_LINES    = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic ser_bit,
    output logic boot_flag
);

    localparam int unsigned ONES_W  = $clog2(BOOT_MIN_LINES + 1);
    localparam int unsigned ZEROS_W = $clog2(CLEAR_LINES + 1);

    typedef struct packed {
        logic [ONES_W-1:0]  ones;
        logic [ZEROS_W-1:0] zeros;
        logic               flag;
    } boot_t;

    boot_t st_d, st_q;
    logic [ONES_W-1:0]  ones_nx;
    logic [ZEROS_W-1:0] zeros_nx;

    always_comb begin
        st_d     = st_q;
        ones_nx  = (st_q.ones == ONES_W'(BOOT_MIN_LINES)) ? st_q.ones
                                                          : st_q.ones + ONES_W'(1);
        zeros_nx = (st_q.zeros == ZEROS_W'(CLEAR_LINES)) ? st_q.zeros
                                                          : st_q.zeros + ZEROS_W'(1);
        if (line_stb) begin
            if (ser_bit) begin
                st_d.ones  = ones_nx;
                st_d.zeros = '0;
                if (ones_nx == ONES_W'(BOOT_MIN_LINES)) begin
                    st_d.flag = 1'b1;
                end
            end else begin
                st_d.ones  = '0;
                st_d.zeros = zeros_nx;
                if (zeros_nx == ZEROS_W'(CLEAR_LINES)) begin
                    st_d.flag = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ones: '0, zeros: '0, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign boot_flag = st_q.flag;

endmodule

// File: rtl/backlink_decode.sv
module backlink_decode
    import term_backlink_pkg::*;
#(
    parameter int unsigned KEY_WORDS = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_vld,
    input  logic [FRAME_BITS-1:0]       frame_word,
    output logic [KEY_WORDS*BODY_W-1:0] key_flat,
    output logic [BODY_W-1:0]           btn_word,
    output logic                        mouse_vld,
    output logic [DELTA_W-1:0]          mouse_dx,
    output logic [DELTA_W-1:0]          mouse_dy
);

    typedef struct packed {
        logic [KEY_WORDS-1:0][BODY_W-1:0] keys;
        logic [BODY_W-1:0]                btn;
        logic                             mvld;
        logic [DELTA_W-1:0]               dx;
        logic [DELTA_W-1:0]               dy;
    } decode_t;

    decode_t st_d, st_q;

    logic              start_bit;
    logic [3:0]        msg_type;
    logic [BODY_W-1:0] body;
    logic [7:0]        trailer;
    logic              accept;
    logic [KEY_WORDS-1:0] key_hit;
    logic              unused_bits;

    assign start_bit   = frame_word[FRAME_BITS-1];
    assign msg_type    = frame_word[27:24];
    assign body        = frame_word[23:8];
    assign trailer     = frame_word[7:0];
    assign unused_bits = ^frame_word[30:28];
    assign accept      = frame_vld && start_bit && (trailer == TRAILER_OK);

    for (genvar gk = 0; gk < KEY_WORDS; gk++) begin : g_key_sel
        assign key_hit[gk] = accept && (msg_type == key_type_code(gk));
    end

    always_comb begin
        st_d      = st_q;
        st_d.mvld = 1'b0;
        for (int k = 0; k < KEY_WORDS; k++) begin
            if (key_hit[k]) begin
                st_d.keys[k] = body;
            end
        end
        if (accept && msg_type == TYPE_BTN) begin
            st_d.btn = body;
        end
        if (accept && msg_type == TYPE_MOUSE) begin
            st_d.mvld = 1'b1;
            st_d.dx   = body[15:8] - 8'd128;
            st_d.dy   = body[7:0]  - 8'd128;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_flat  = st_q.keys;
    assign btn_word  = st_q.btn;
    assign mouse_vld = st_q.mvld;
    assign mouse_dx  = st_q.dx;
    assign mouse_dy  = st_q.dy;

endmodule

// File: rtl/term_backlink_rx.sv
module term_backlink_rx
    import term_backlink_pkg::*;
#(
    parameter int unsigned KEY_WORDS      = 6,
    parameter int unsigned BOOT_MIN_LINES = 40,
    parameter int unsigned CLEAR_LINES    = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        line_stb,
    input  logic                        ser_bit,
    output logic [KEY_WORDS*BODY_W-1:0] key_flat,
    output logic [BODY_W-1:0]           btn_word,
    output logic                        mouse_vld,
    output logic [DELTA_W-1:0]          mouse_dx,
    output logic [DELTA_W-1:0]          mouse_dy,
    output logic                        boot_flag
);

    logic                  frame_vld;
    logic [FRAME_BITS-1:0] frame_word;

    backlink_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_stb   (line_stb),
        .ser_bit    (ser_bit),
        .frame_vld  (frame_vld),
        .frame_word (frame_word)
    );

    backlink_decode #(
        .KEY_WORDS (KEY_WORDS)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .frame_word (frame_word),
        .key_flat   (key_flat),
        .btn_word   (btn_word),
        .mouse_vld  (mouse_vld),
        .mouse_dx   (mouse_dx),
        .mouse_dy   (mouse_dy)
    );

    backlink_boot_det #(
        .BOOT_MIN_LINES (BOOT_MIN_LINES),
        .CLEAR_LINES    (CLEAR_LINES)
    ) u_boot (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_stb  (line_stb),
        .ser_bit   (ser_bit),
        .boot_flag (boot_flag)
    );

endmodule

// File: rtl/term_backlink_rx_chk.sv
module term_backlink_rx_chk
    import term_backlink_pkg::*;
#(
    parameter int unsigned KEY_WORDS = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        line_stb,
    input logic                        ser_bit,
    input logic                        frame_vld,
    input logic [FRAME_BITS-1:0]       frame_word,
    input logic [KEY_WORDS*BODY_W-1:0] key_flat,
    input logic [BODY_W-1:0]           btn_word,
    input logic                        mouse_vld,
    input logic                        boot_flag
);

    // R6
    mouse_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mouse_vld |=> !mouse_vld);

    // R3
    mouse_trailer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mouse_vld |-> ($past(frame_vld) && $past(frame_word[7:0]) == TRAILER_OK));

    // R4
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(line_stb, 2) |-> $stable(key_flat));

    // R5
    btn_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(btn_word) |-> ($past(frame_vld) && $past(frame_word[27:24]) == TYPE_BTN));

    // R8
    boot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_flag) |-> $past(line_stb && ser_bit));

    // R9
    boot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(boot_flag) |-> $past(line_stb && !ser_bit));

endmodule

bind term_backlink_rx term_backlink_rx_chk #(.KEY_WORDS(KEY_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_stb   (line_stb),
    .ser_bit    (ser_bit),
    .frame_vld  (frame_vld),
    .frame_word (frame_word),
    .key_flat   (key_flat),
    .btn_word   (btn_word),
    .mouse_vld  (mouse_vld),
    .boot_flag  (boot_flag)
);

// File: tb/test_term_backlink_rx.sv
module test_term_backlink_rx;

    localparam int KW  = 6;
    localparam int NV  = 16;
    localparam int BMIN = 40;
    localparam int CLR  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_stb = 1'b0;
    logic ser_bit = 1'b0;
    logic [KW*16-1:0] key_flat;
    logic [15:0] btn_word;
    logic        mouse_vld;
    logic [7:0]  mouse_dx, mouse_dy;
    logic        boot_flag;

    always #4 clk = ~clk;

    term_backlink_rx #(.KEY_WORDS(KW), .BOOT_MIN_LINES(BMIN), .CLEAR_LINES(CLR))
    i_term_backlink_rx (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .ser_bit(ser_bit),
        .key_flat(key_flat), .btn_word(btn_word), .mouse_vld(mouse_vld),
        .mouse_dx(mouse_dx), .mouse_dy(mouse_dy), .boot_flag(boot_flag)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // mouse pulse monitor
    int   m_pulses = 0;
    int   m_wide = 0;
    logic m_prev = 1'b0;
    logic [7:0] m_dx = '0, m_dy = '0;
    always @(negedge clk) begin
        if (mouse_vld && !m_prev) begin
            m_pulses++;
            m_dx = mouse_dx;
            m_dy = mouse_dy;
        end
        if (mouse_vld && m_prev) m_wide++;
        m_prev = mouse_vld;
    end

    // model state
    logic [15:0] key_m [KW];
    logic [15:0] btn_m;
    int          pulses_m;
    logic [7:0]  dx_m, dy_m;

    // {gap[3:0], unused[2:0], type[3:0], body[15:0], trailer[7:0]}
    localparam logic [34:0] VEC [NV] = '{
        {4'd3, 3'd0, 4'd1,  16'h1234, 8'h80},
        {4'd0, 3'd7, 4'd4,  16'hABCD, 8'h80},
        {4'd2, 3'd5, 4'd5,  16'h0F0F, 8'h80},
        {4'd1, 3'd0, 4'd8,  16'h5555, 8'h80},
        {4'd0, 3'd2, 4'd9,  16'hAAAA, 8'h80},
        {4'd2, 3'd0, 4'd6,  16'h857B, 8'h80},
        {4'd1, 3'd0, 4'd0,  16'hFFFF, 8'h80},
        {4'd1, 3'd0, 4'd7,  16'hFFFF, 8'h80},
        {4'd1, 3'd0, 4'd10, 16'h1111, 8'h80},
        {4'd1, 3'd0, 4'd14, 16'h2222, 8'h80},
        {4'd1, 3'd0, 4'd15, 16'h3333, 8'h80},
        {4'd2, 3'd0, 4'd2,  16'hBEEF, 8'h81},
        {4'd2, 3'd0, 4'd6,  16'h4444, 8'h00},
        {4'd1, 3'd0, 4'd3,  16'h0001, 8'h80},
        {4'd0, 3'd0, 4'd6,  16'h00FF, 8'h80},
        {4'd1, 3'd1, 4'd2,  16'hC0DE, 8'h80}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_line(logic b);
        @(negedge clk);
        ser_bit  = b;
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_run(logic b, int n);
        for (int i = 0; i < n; i++) send_line(b);
    endtask

    task automatic send_msg(logic [2:0] u, logic [3:0] t, logic [15:0] body, logic [7:0] tr);
        logic [31:0] w;
        w = {1'b1, u, t, body, tr};
        for (int i = 31; i >= 0; i--) send_line(w[i]);
    endtask

    task automatic model_apply(logic [3:0] t, logic [15:0] body, logic [7:0] tr);
        if (tr == 8'h80) begin
            case (t)
                4'd1, 4'd2, 4'd3, 4'd4: key_m[t - 1] = body;
                4'd8, 4'd9:             key_m[t - 4] = body;
                4'd5:                   btn_m = body;
                4'd6: begin
                    pulses_m++;
                    dx_m = body[15:8] - 8'd128;
                    dy_m = body[7:0]  - 8'd128;
                end
                default: ;
            endcase
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < KW; k++) key_m[k] = '0;
        btn_m = '0;
    endtask

    task automatic check_state(string tag);
        for (int k = 0; k < KW; k++) check(tag, 32'(key_flat[k*16 +: 16]), 32'(key_m[k]));
        check(tag, 32'(btn_word), 32'(btn_m));
        check(tag, 32'(m_pulses), 32'(pulses_m));
    endtask

    function automatic string vec_tag(logic [3:0] gap, logic [3:0] t, logic [7:0] tr);
        string s;
        if (tr != 8'h80)                        s = "R3";
        else if (t inside {1, 2, 3, 4, 8, 9})   s = "R4";
        else if (t == 5)                        s = "R5";
        else if (t == 6)                        s = "R6";
        else                                    s = "R7";
        s = {s, " R2"};
        if (gap == 0) s = {s, " R10"};
        else          s = {s, " R1"};
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        pulses_m = 0;
        dx_m = '0;
        dy_m = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 keys", 32'(key_flat[31:0]), 32'h0);
        check("R11 btn", 32'(btn_word), 32'h0);
        check("R11 boot", 32'(boot_flag), 32'h0);
        check("R11 mouse", 32'(mouse_vld), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table-driven messages
        for (int v = 0; v < NV; v++) begin
            logic [34:0] e;
            e = VEC[v];
            send_run(1'b0, int'(e[34:31]));
            send_msg(e[30:28], e[27:24], e[23:8], e[7:0]);
            model_apply(e[27:24], e[23:8], e[7:0]);
            check_state(vec_tag(e[34:31], e[27:24], e[7:0]));
            if (e[27:24] == 4'd6 && e[7:0] == 8'h80) begin
                check("R6 dx", 32'(m_dx), 32'(dx_m));
                check("R6 dy", 32'(m_dy), 32'(dy_m));
            end
        end
        check("R6 pulse width", 32'(m_wide), 32'h0);

        // R11 reset in the middle of a message
        begin
            logic [31:0] w;
            w = {1'b1, 3'd0, 4'd1, 16'hFFFF, 8'h80};
            for (int i = 31; i >= 22; i--) send_line(w[i]);
        end
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        check_state("R11 cleared");
        check("R11 boot", 32'(boot_flag), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        send_msg(3'd0, 4'd1, 16'h0042, 8'h80);
        model_apply(4'd1, 16'h0042, 8'h80);
        check_state("R11 reframe");

        // R8 short push rejected
        send_run(1'b1, BMIN - 1);
        check("R8 short run", 32'(boot_flag), 32'h0);
        send_run(1'b0, 25);
        check_state("R3 all-ones frame dropped");

        // R8 boot set at threshold
        send_run(1'b1, BMIN - 1);
        check("R8 one below", 32'(boot_flag), 32'h0);
        send_line(1'b1);
        check("R8 threshold", 32'(boot_flag), 32'h1);
        send_run(1'b1, 5);
        // R9 garbage after release keeps flag
        begin
            logic [7:0] g;
            g = 8'b1011_0010;
            for (int i = 7; i >= 0; i--) send_line(g[i]);
        end
        send_run(1'b0, CLR - 2);
        check("R9 zero run short", 32'(boot_flag), 32'h1);
        send_line(1'b0);
        check("R9 clear", 32'(boot_flag), 32'h0);
        send_run(1'b0, 30);
        check_state("R3 boot frames dropped");
        send_msg(3'd0, 4'd5, 16'h0BAD, 8'h80);
        model_apply(4'd5, 16'h0BAD, 8'h80);
        check_state("R5 after boot");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule